// File: doc/BRIEF.md
# Shift-XOR Branch History Register

This block keeps a global record of recently taken branches, meant to form part of the index into an indirect-branch predictor. Each cycle the front end may present at most one resolved branch event, with a valid flag, a taken flag, the branch's source address and its target address. When the event is valid and taken, the register moves its whole content up by two bit positions and folds a 20-bit fingerprint of that branch into the bottom.

The fingerprint pairs each of the low target bits with a source bit six positions higher. Because the two bits of a pair are combined by XOR, a branch whose two bits of one pair are both inverted leaves the same trace as the original branch. The register is 58 bits wide and is never shifted right, so information from an old branch only moves toward the top and is lost after enough later insertions. The current value is driven straight from the register and can be concatenated or hashed into a predictor index by the consumer.

Top module: `bhr_top`

## Requirements
- R1: A synchronous active-low reset (rst_n low at a rising clock edge) clears hist_o to all zeros.
- R2: When br_valid and br_taken are both 1 at a rising edge, hist_o after that edge equals the old value shifted left by 2 (top two bits dropped, two zeros entering at bit 0) XOR the 20-bit fingerprint zero-extended to 58 bits.
- R3: When br_valid is 0, or br_valid is 1 with br_taken 0, hist_o keeps its value across the edge.
- R4: Fingerprint bit k (k = 0 to 19) is br_tgt[k] XOR br_src[k+6]; in particular bit 0 is br_tgt[0]^br_src[6] and bit 1 is br_tgt[1]^br_src[7].
- R5: Inverting br_tgt[0] together with br_src[6], or br_tgt[1] together with br_src[7], in an inserted branch leaves hist_o unchanged.
- R6: Address bits outside br_tgt[19:0] and br_src[25:6] have no effect on hist_o.
- R7: A taken branch followed by 28 taken branches whose fingerprint is zero can still be seen in hist_o (its fingerprint bits 0 and 1 sit at hist_o bits 56 and 57); after 29 or more such branches it has no effect.
- R8: The value produced by an insertion appears on hist_o in the first cycle after the insertion edge, one update per edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| br_valid | input | 1 | A resolved branch event is present this cycle |
| br_taken | input | 1 | The presented branch was taken |
| br_src | input | 48 | Source address of the branch |
| br_tgt | input | 48 | Target address of the branch |
| hist_o | output | 58 | Current history value |

## Verification
The embedded assertions check on every cycle that reset clears the register, that idle and not-taken cycles hold it steady, that the bits above the fingerprint field are a pure two-bit upward move of the old content, and that the bottom two bits after an insertion equal the paired target and source bits of that branch. The cancellation of paired bit flips, the insensitivity to unused address bits and the exact ageing window of 28 against 29 later branches depend on sequences of events, so only the bench's directed scenarios show them, while its random stream compares every cycle against a reference computed from the requirements.

// File: rtl/bhr_pkg.sv
// Package: shared defaults for the branch history register.
// Assumes: consumers derive all local widths from these values.
package bhr_pkg;
    localparam int DEF_ADDR_W  = 48; // branch address width
    localparam int DEF_HIST_W  = 58; // history register width
    localparam int DEF_FP_W    = 20; // fingerprint width
    localparam int DEF_SHIFT   = 2;  // bits moved up per insertion
    localparam int DEF_SRC_OFS = 6;  // source bit paired with target bit 0
endpackage

// File: rtl/bhr_fold.sv
// Module: bhr_fold
// Builds the per-branch fingerprint: bit k = target bit k XOR source bit
// (k + SRC_OFS). Pure combinational.
// Assumes: the caller hands over only the needed address slices.
module bhr_fold #(
    parameter int FP_W = bhr_pkg::DEF_FP_W
) (
    input  logic [FP_W-1:0] tgt_bits,
    input  logic [FP_W-1:0] src_bits,
    output logic [FP_W-1:0] fp
);
    // One XOR pair per fingerprint bit.
    for (genvar k = 0; k < FP_W; k++) begin : g_pair
        assign fp[k] = tgt_bits[k] ^ src_bits[k];
    end
endmodule

// File: rtl/bhr_shift_core.sv
// Module: bhr_shift_core
// Holds the history; on ins it moves content up by SHIFT bits and XORs the
// zero-extended fingerprint into the bottom.
// Assumes: HIST_W > FP_W >= SHIFT; at most one insertion per cycle.
module bhr_shift_core #(
    parameter int HIST_W = bhr_pkg::DEF_HIST_W,
    parameter int FP_W   = bhr_pkg::DEF_FP_W,
    parameter int SHIFT  = bhr_pkg::DEF_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins,
    input  logic [FP_W-1:0]   fp,
    output logic [HIST_W-1:0] hist
);
    localparam int PAD_W = HIST_W - FP_W;

    logic [HIST_W-1:0] hist_q;
    logic [HIST_W-1:0] hist_d;

    // Next value: upward move with zero fill, then fold in the fingerprint.
    always_comb begin
        hist_d = {hist_q[HIST_W-1-SHIFT:0], {SHIFT{1'b0}}} ^ {{PAD_W{1'b0}}, fp};
    end

    // Register: synchronous clear, update only on a taken insertion.
    always_ff @(posedge clk) begin
        if (!rst_n)   hist_q <= '0;
        else if (ins) hist_q <= hist_d;
    end

    assign hist = hist_q;

    // R1: reset clears the history.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> hist_q == '0);

    // R3: no insertion, no change.
    assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ins |=> $stable(hist_q));

    // R2: bits above the fingerprint field are the old content moved up.
    assert_upper_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ins |=> hist_q[HIST_W-1:FP_W] == $past(hist_q[HIST_W-1-SHIFT:FP_W-SHIFT]));
endmodule

// File: rtl/bhr_top.sv
// Module: bhr_top
// Global shift-XOR branch history register for an indirect predictor index.
// Assumes: one branch event per cycle; only valid and taken events insert.
module bhr_top #(
    parameter int ADDR_W  = bhr_pkg::DEF_ADDR_W,
    parameter int HIST_W  = bhr_pkg::DEF_HIST_W,
    parameter int FP_W    = bhr_pkg::DEF_FP_W,
    parameter int SHIFT   = bhr_pkg::DEF_SHIFT,
    parameter int SRC_OFS = bhr_pkg::DEF_SRC_OFS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_valid,
    input  logic              br_taken,
    input  logic [ADDR_W-1:0] br_src,
    input  logic [ADDR_W-1:0] br_tgt,
    output logic [HIST_W-1:0] hist_o
);
    localparam int SRC_HI = SRC_OFS + FP_W - 1;

    logic            ins;
    logic [FP_W-1:0] fp;
    logic            unused_addr_bits;

    // Insert only for a present, taken branch.
    assign ins = br_valid & br_taken;

    // Address bits outside the fingerprint slices are read only here.
    assign unused_addr_bits = ^{br_src, br_tgt};

    bhr_fold #(.FP_W(FP_W)) u_fold (
        .tgt_bits (br_tgt[FP_W-1:0]),
        .src_bits (br_src[SRC_HI:SRC_OFS]),
        .fp       (fp)
    );

    bhr_shift_core #(.HIST_W(HIST_W), .FP_W(FP_W), .SHIFT(SHIFT)) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .ins   (ins),
        .fp    (fp),
        .hist  (hist_o)
    );

    // R4: after an insertion the bottom bits equal the paired address bits.
    assert_low_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && br_taken) |=> hist_o[SHIFT-1:0] ==
            $past(br_tgt[SHIFT-1:0] ^ br_src[SRC_OFS+SHIFT-1:SRC_OFS]));
endmodule

// File: tb/tb_bhr_top.sv
// Bench for bhr_top: random event stream plus directed corner cases.
module tb_bhr_top;
    localparam int ADDR_W = 48;
    localparam int HIST_W = 58;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              br_valid = 1'b0;
    logic              br_taken = 1'b0;
    logic [ADDR_W-1:0] br_src = '0;
    logic [ADDR_W-1:0] br_tgt = '0;
    logic [HIST_W-1:0] hist_o;

    int n_checks = 0;
    int n_fails  = 0;
    logic [HIST_W-1:0] model = '0;
    logic done = 1'b0;

    bhr_top dut (
        .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_taken(br_taken),
        .br_src(br_src), .br_tgt(br_tgt), .hist_o(hist_o)
    );

    always #10 clk = ~clk; // 50 MHz

    // Reference fingerprint from R4.
    function automatic logic [19:0] fp_ref(input logic [ADDR_W-1:0] s,
                                           input logic [ADDR_W-1:0] t);
        logic [19:0] f;
        for (int k = 0; k < 20; k++) f[k] = t[k] ^ s[k+6];
        return f;
    endfunction

    // Reference update from R2.
    function automatic logic [HIST_W-1:0] next_ref(input logic [HIST_W-1:0] h,
                                                   input logic [19:0] f);
        return (h << 2) ^ HIST_W'(f);
    endfunction

    task automatic check(input string req, input logic [HIST_W-1:0] exp);
        n_checks++;
        if (hist_o !== exp) begin
            n_fails++;
            $display("FAIL %s: hist_o=%h expected=%h", req, hist_o, exp);
        end
    endtask

    // Apply one cycle from a negedge; returns at the following negedge.
    task automatic step(input logic v, input logic tk,
                        input logic [ADDR_W-1:0] s, input logic [ADDR_W-1:0] t);
        br_valid = v; br_taken = tk; br_src = s; br_tgt = t;
        @(posedge clk);
        if (v && tk) model = next_ref(model, fp_ref(s, t));
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; br_valid = 1'b0; br_taken = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model = '0;
        check("R1", '0);
    endtask

    function automatic logic [ADDR_W-1:0] rnd_addr();
        logic [63:0] w;
        w = {$urandom(), $urandom()};
        return w[ADDR_W-1:0];
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [HIST_W-1:0] ref_a;
        logic [ADDR_W-1:0] sa, ta;
        void'($urandom(32'd4242));
        @(negedge clk);
        do_reset();

        // R2 / R8: single insertion visible right after its edge.
        step(1'b1, 1'b1, 48'h0000_0000_0040, 48'h0000_0000_0003);
        check("R2", HIST_W'(2));  // fp = 3 ^ 1 = 2
        check("R8", model);

        // R3: not-taken and idle cycles hold.
        step(1'b1, 1'b0, rnd_addr(), rnd_addr());
        check("R3", HIST_W'(2));
        step(1'b0, 1'b1, rnd_addr(), rnd_addr());
        check("R3", HIST_W'(2));

        // R4: pattern on bits 0,1 and a high fingerprint bit.
        do_reset();
        step(1'b1, 1'b1, 48'h0000_0000_0080, 48'h0000_0000_0001);
        check("R4", HIST_W'(3));
        do_reset();
        step(1'b1, 1'b1, 48'h0000_0200_0000, 48'h0000_0000_0000);
        check("R4", HIST_W'(20'h80000));

        // R5: paired flips cancel.
        sa = rnd_addr(); ta = rnd_addr();
        do_reset();
        step(1'b1, 1'b1, sa, ta);
        ref_a = hist_o;
        do_reset();
        step(1'b1, 1'b1, sa ^ 48'h40, ta ^ 48'h1);
        check("R5", ref_a);
        do_reset();
        step(1'b1, 1'b1, sa ^ 48'h80, ta ^ 48'h2);
        check("R5", ref_a);

        // R6: bits outside the used slices do nothing.
        do_reset();
        step(1'b1, 1'b1, sa ^ 48'hFFFF_FC00_003F, ta ^ 48'hFFFF_FFF0_0000);
        check("R6", ref_a);

        // R7: ageing window of 28 against 29 later branches.
        do_reset();
        step(1'b1, 1'b1, '0, 48'h1);
        for (int i = 0; i < 28; i++) step(1'b1, 1'b1, '0, '0);
        check("R7", HIST_W'(1) << 56);
        step(1'b1, 1'b1, '0, '0);
        check("R7", '0);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, '0, '0);
        check("R7", '0);

        // Random stream against the reference.
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            step(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 3) != 0),
                 rnd_addr(), rnd_addr());
            check("R2", model);
            if (i == 1500) do_reset();
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule